// File: doc/BRIEF.md
# Relocatable GPIO Host Port Decoder

This block decodes a movable window of byte-wide ports on a simple host I/O bus and routes the accesses to a bank of GPIO data groups. The window starts at a 16-bit base address and answers only while the block is enabled. A range bit sets the window to 8 bytes or to 16 bytes. The two lowest ports form an index/data pair that reaches a small internal register array. The other decoded ports are direct ports, one for each GPIO data group.

A direct port does not act the same way for reads and writes. A write loads that group's output latch, which drives the `gpio_out` bus. A read returns the group's pin levels, taken from `gpio_pin` through a two-flop synchronizer. The read therefore shows what the pins carry, which can differ from the value last written. Reads return data on a registered, single-cycle response. An access outside the window, or any access while the block is disabled, gets no response.

The enable bit, the two base-address bytes and the range bit are loaded through a small configuration port. That port stands in for the wider configuration space. Each configuration register can be read back on the same port.

Top module: `gpio_port_decoder`

## Requirements
- R1: After reset the enable bit is 0, the base address is 0x0060, the range bit is 0, the index is 0x00 and every group output latch is 0x00. Configuration select 0 reads the enable bit in bit 0, and bits 7:1 always read as 0, even after a write of 0xFF. Select 1 reads the high base byte. Select 2 reads the low base byte. Select 3 reads the range bit in bit 0.
- R2: While the enable bit is 0, a read in the window gives no response (`bus_rvalid` stays 0) and a write in the window changes nothing.
- R3: With the range bit at 0, only offsets 0 to 7 from the base respond. Offset 8 and above gives no response, and a write there is ignored.
- R4: With the range bit at 1, offsets 8, 9 and 10 are the direct ports of groups 2, 3 and 4. Offsets 11 to 15 respond to reads with 0x00 and ignore writes. Offset 16 and above gives no response.
- R5: The window base is {high byte, low byte}. After the base changes, the ports answer at the new base and no longer at the old one.
- R6: Offset 0 is the index port: a write sets the 8-bit index, and a read returns it. Offset 1 is the data port: it reads or writes the array entry that the index selects. The index holds its value until it is written again.
- R7: Offsets 2 to 7 are the direct ports of groups 8, 7, 6, 5, 0 and 1, in that order. A write to a direct port loads that group's output latch and no other latch.
- R8: A read of a direct port returns the group's pin levels after the two-flop synchronizer, not its output latch.
- R9: A read that hits the window raises `bus_rvalid` for exactly one cycle, in the cycle after the read strobe, with the data on `bus_rdata`. When `bus_rvalid` is 0, `bus_rdata` is 0x00.
- R10: An index at or above the array depth (16) reads 0x00 through the data port. A write through the data port at such an index changes no array entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Configuration register select: 0 enable, 1 base high, 2 base low, 3 range |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register value |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read response valid |
| gpio_pin | input | 72 | Pin levels, group g in bits [8g+7:8g] |
| gpio_out | output | 72 | Output latches, group g in bits [8g+7:8g] |

## Verification
The assertions are checked on every cycle. They cover four things. A response follows only a read that hit the window, and never a read while the block is disabled. The read data is zero whenever no response is valid. The index, the base registers and the group latches change only when their write strobe is active. The bench scenarios cover what the assertions cannot see. These are the offset-to-group order, the two window sizes and the reserved offsets, and moving the base. They also cover the index/data sequence with out-of-depth indices, and pin values forced to differ from the latch value, which a direct-port read must return.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_INDEX = 2'd1,
    PK_DATA  = 2'd2,
    PK_GROUP = 2'd3
  } port_kind_t;

  // Offset inside the window -> direct group number (the order is behaviour)
  function automatic logic [4:0] group_of(input logic [3:0] off);
    logic [4:0] r;  // {valid, group[3:0]}
    case (off)
      4'd2:    r = {1'b1, 4'd8};
      4'd3:    r = {1'b1, 4'd7};
      4'd4:    r = {1'b1, 4'd6};
      4'd5:    r = {1'b1, 4'd5};
      4'd6:    r = {1'b1, 4'd0};
      4'd7:    r = {1'b1, 4'd1};
      4'd8:    r = {1'b1, 4'd2};
      4'd9:    r = {1'b1, 4'd3};
      4'd10:   r = {1'b1, 4'd4};
      default: r = 5'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpd_cfg_regs.sv
module gpd_cfg_regs #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_RESET = 16'h0060
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              enable,
  output logic              range_wide,
  output logic [ADDR_W-1:0] base
);
  localparam int HALF = ADDR_W / 2;

  logic [HALF-1:0] base_hi_q, base_lo_q;
  logic            en_q, wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      wide_q    <= 1'b0;
      base_hi_q <= BASE_RESET[ADDR_W-1:HALF];
      base_lo_q <= BASE_RESET[HALF-1:0];
    end else if (cfg_wr) begin
      case (cfg_sel)
        2'd0: en_q      <= cfg_wdata[0];
        2'd1: base_hi_q <= cfg_wdata[HALF-1:0];
        2'd2: base_lo_q <= cfg_wdata[HALF-1:0];
        default: wide_q <= cfg_wdata[0];
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      2'd0: cfg_rdata[0]      = en_q;
      2'd1: cfg_rdata[HALF-1:0] = base_hi_q;
      2'd2: cfg_rdata[HALF-1:0] = base_lo_q;
      default: cfg_rdata[0]   = wide_q;
    endcase
  end

  assign enable     = en_q;
  assign range_wide = wide_q;
  assign base       = {base_hi_q, base_lo_q};

  // R5
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(base));

endmodule

// File: rtl/gpd_window_decode.sv
module gpd_window_decode
  import gpd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GRP_W  = 4
) (
  input  logic              enable,
  input  logic              range_wide,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output port_kind_t        kind,
  output logic [GRP_W-1:0]  group
);
  localparam int WIN_BITS = 4;

  logic [ADDR_W:0]   diff;
  logic [WIN_BITS-1:0] off;
  logic [4:0]        gmap;
  logic              in_win;

  always_comb begin
    diff   = {1'b0, addr} - {1'b0, base};
    off    = diff[WIN_BITS-1:0];
    in_win = !diff[ADDR_W] && (diff[ADDR_W-1:WIN_BITS] == '0) &&
             (range_wide || !off[WIN_BITS-1]);
    hit    = enable && in_win;
    gmap   = group_of(off);
    group  = GRP_W'(gmap[3:0]);
    if (!hit)             kind = PK_NONE;
    else if (off == 4'd0) kind = PK_INDEX;
    else if (off == 4'd1) kind = PK_DATA;
    else if (gmap[4])     kind = PK_GROUP;
    else                  kind = PK_NONE;
  end

endmodule

// File: rtl/gpd_index_file.sv
module gpd_index_file #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] idx_q,
  output logic [DATA_W-1:0] data_rd
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DATA_W:0] DEPTH_L = (DATA_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_range;
  logic [AW-1:0]     waddr;

  assign in_range = {1'b0, idx_q} < DEPTH_L;
  assign waddr    = AW'(idx_q);

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= wdata;
  end

  // No reset on the array so it may map to RAM
  always_ff @(posedge clk) begin
    if (data_wr && in_range) mem[waddr] <= wdata;
  end

  assign data_rd = in_range ? mem[waddr] : '0;

  // R6
  index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !idx_wr |=> $stable(idx_q));

endmodule

// File: rtl/gpd_group_bank.sv
module gpd_group_bank #(
  parameter int DATA_W     = 8,
  parameter int NUM_GROUPS = 9,
  parameter int GRP_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [GRP_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [GRP_W-1:0]             rd_sel,
  input  logic [NUM_GROUPS*DATA_W-1:0] pins,
  output logic [NUM_GROUPS*DATA_W-1:0] out_flat,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] sync1 [NUM_GROUPS];
  logic [DATA_W-1:0] sync2 [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [DATA_W-1:0] latch_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        latch_q  <= '0;
        sync1[g] <= '0;
        sync2[g] <= '0;
      end else begin
        if (wr_en && wr_sel == GRP_W'(g)) latch_q <= wdata;
        sync1[g] <= pins[g*DATA_W +: DATA_W];
        sync2[g] <= sync1[g];
      end
    end

    assign out_flat[g*DATA_W +: DATA_W] = latch_q;
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (rd_sel == GRP_W'(g)) rd_data = sync2[g];
  end

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(out_flat));

endmodule

// File: rtl/gpio_port_decoder.sv
module gpio_port_decoder
  import gpd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_GROUPS = 9,
  parameter int IDX_DEPTH  = 16,
  parameter logic [ADDR_W-1:0] BASE_RESET = 16'h0060
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_wr,
  input  logic [1:0]                   cfg_sel,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [DATA_W-1:0]            cfg_rdata,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         bus_rvalid,
  input  logic [NUM_GROUPS*DATA_W-1:0] gpio_pin,
  output logic [NUM_GROUPS*DATA_W-1:0] gpio_out
);
  localparam int GRP_W = 4;

  logic              enable, range_wide, hit;
  logic [ADDR_W-1:0] base;
  port_kind_t        kind;
  logic [GRP_W-1:0]  group;
  logic [DATA_W-1:0] idx_q, idx_data, grp_data, rd_mux;

  gpd_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_RESET(BASE_RESET)) u_cfg (
    .clk, .rst, .cfg_wr, .cfg_sel, .cfg_wdata, .cfg_rdata,
    .enable, .range_wide, .base
  );

  gpd_window_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_dec (
    .enable, .range_wide, .base, .addr(bus_addr), .hit, .kind, .group
  );

  gpd_index_file #(.DATA_W(DATA_W), .DEPTH(IDX_DEPTH)) u_idx (
    .clk, .rst,
    .idx_wr (bus_wr && kind == PK_INDEX),
    .data_wr(bus_wr && kind == PK_DATA),
    .wdata  (bus_wdata),
    .idx_q, .data_rd(idx_data)
  );

  gpd_group_bank #(.DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_grp (
    .clk, .rst,
    .wr_en  (bus_wr && kind == PK_GROUP),
    .wr_sel (group),
    .wdata  (bus_wdata),
    .rd_sel (group),
    .pins   (gpio_pin),
    .out_flat(gpio_out),
    .rd_data(grp_data)
  );

  always_comb begin
    case (kind)
      PK_INDEX: rd_mux = idx_q;
      PK_DATA:  rd_mux = idx_data;
      PK_GROUP: rd_mux = grp_data;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd && hit;
      bus_rdata  <= (bus_rd && hit) ? rd_mux : '0;
    end
  end

  // R2
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !enable) |=> !bus_rvalid);

  // R9
  resp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> bus_rdata == '0);

endmodule

// File: tb/tb_gpio_port_decoder.sv
module tb_gpio_port_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [71:0] gpio_pin = '0;
  logic [71:0] gpio_out;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] exp_out [9];

  typedef struct { logic v; logic [7:0] d; string tag; } item_t;
  item_t sbq[$];

  gpio_port_decoder dut (
    .clk, .rst, .cfg_wr, .cfg_sel, .cfg_wdata, .cfg_rdata,
    .bus_addr, .bus_wdata, .bus_rd, .bus_wr, .bus_rdata, .bus_rvalid,
    .gpio_pin, .gpio_out
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops the expected response for every read strobe
  always @(posedge clk) begin
    logic took;
    item_t it;
    took = bus_rd;
    #1;
    if (took && sbq.size() > 0) begin
      it = sbq.pop_front();
      vectors++;
      if (bus_rvalid !== it.v || bus_rdata !== it.d) begin
        miscompares++;
        $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
                 it.tag, bus_rvalid, bus_rdata, it.v, it.d);
      end
    end
  end

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h, expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    for (int g = 0; g < 9; g++) check8(gpio_out[g*8 +: 8], exp_out[g], tag);
  endtask

  task automatic bus_read(input logic [15:0] a, input logic v, input logic [7:0] d,
                          input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.v = v; it.d = d; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cfg_set(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_check(input logic [1:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = s;
    #1;
    check8(cfg_rdata, exp, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    for (int g = 0; g < 9; g++) exp_out[g] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    cfg_check(2'd0, 8'h00, "R1 enable reset");
    cfg_check(2'd1, 8'h00, "R1 base high reset");
    cfg_check(2'd2, 8'h60, "R1 base low reset");
    cfg_check(2'd3, 8'h00, "R1 range reset");
    check_outs("R1 latch reset");

    // R2 disabled: no response, writes ignored
    bus_read(16'h0062, 1'b0, 8'h00, "R2 read while disabled");
    bus_write(16'h0062, 8'hEE);
    check_outs("R2 write while disabled");

    // R1 reserved enable bits read 0
    cfg_set(2'd0, 8'hFF);
    cfg_check(2'd0, 8'h01, "R1 enable reserved bits");

    // R6 index reset value
    bus_read(16'h0060, 1'b1, 8'h00, "R6 index reset read");

    // R7 direct writes, offset order 8,7,6,5,0,1
    bus_write(16'h0062, 8'hA8); exp_out[8] = 8'hA8;
    bus_write(16'h0063, 8'hA7); exp_out[7] = 8'hA7;
    bus_write(16'h0064, 8'hA6); exp_out[6] = 8'hA6;
    bus_write(16'h0065, 8'hA5); exp_out[5] = 8'hA5;
    bus_write(16'h0066, 8'hA0); exp_out[0] = 8'hA0;
    bus_write(16'h0067, 8'hA1); exp_out[1] = 8'hA1;
    check_outs("R7 direct port map");

    // R8 pins differ from latch, read returns synchronized pins
    @(negedge clk);
    for (int g = 0; g < 9; g++) gpio_pin[g*8 +: 8] = 8'h30 + 8'(g);
    repeat (3) @(negedge clk);
    bus_read(16'h0062, 1'b1, 8'h38, "R8 group8 pins");
    bus_read(16'h0066, 1'b1, 8'h30, "R8 group0 pins");
    bus_read(16'h0067, 1'b1, 8'h31, "R8 group1 pins");

    // R3 narrow window
    bus_read(16'h0068, 1'b0, 8'h00, "R3 offset 8 narrow");
    bus_write(16'h0068, 8'h55);
    check_outs("R3 write outside narrow window");
    bus_read(16'h005F, 1'b0, 8'h00, "R3 below base");

    // R4 wide window
    cfg_set(2'd3, 8'h01);
    cfg_check(2'd3, 8'h01, "R1 range readback");
    bus_write(16'h0068, 8'hB2); exp_out[2] = 8'hB2;
    bus_write(16'h0069, 8'hB3); exp_out[3] = 8'hB3;
    bus_write(16'h006A, 8'hB4); exp_out[4] = 8'hB4;
    check_outs("R4 offsets 8..10");
    bus_read(16'h006A, 1'b1, 8'h34, "R4 group4 pins");
    bus_read(16'h006B, 1'b1, 8'h00, "R4 reserved offset 11");
    bus_read(16'h006F, 1'b1, 8'h00, "R4 reserved offset 15");
    bus_write(16'h006C, 8'h77);
    check_outs("R4 reserved write ignored");
    bus_read(16'h0070, 1'b0, 8'h00, "R4 offset 16");

    // R6 index/data sequence
    bus_write(16'h0060, 8'h05);
    bus_write(16'h0061, 8'h77);
    bus_write(16'h0060, 8'h06);
    bus_write(16'h0061, 8'h88);
    bus_write(16'h0060, 8'h00);
    bus_write(16'h0061, 8'h11);
    bus_write(16'h0060, 8'h05);
    bus_read(16'h0061, 1'b1, 8'h77, "R6 data entry 5");
    bus_read(16'h0060, 1'b1, 8'h05, "R6 index readback");
    bus_read(16'h0061, 1'b1, 8'h77, "R6 index persists");
    bus_write(16'h0060, 8'h06);
    bus_read(16'h0061, 1'b1, 8'h88, "R6 data entry 6");

    // R10 out of depth index
    bus_write(16'h0060, 8'h10);
    bus_write(16'h0061, 8'h99);
    bus_read(16'h0061, 1'b1, 8'h00, "R10 index 16 read");
    bus_write(16'h0060, 8'hF5);
    bus_write(16'h0061, 8'h9A);
    bus_write(16'h0060, 8'h00);
    bus_read(16'h0061, 1'b1, 8'h11, "R10 entry 0 untouched");
    bus_write(16'h0060, 8'h05);
    bus_read(16'h0061, 1'b1, 8'h77, "R10 entry 5 untouched");

    // R5 relocation
    cfg_set(2'd1, 8'h12);
    cfg_set(2'd2, 8'h40);
    cfg_check(2'd1, 8'h12, "R5 base high readback");
    bus_read(16'h0062, 1'b0, 8'h00, "R5 old base silent");
    bus_write(16'h1242, 8'hC8); exp_out[8] = 8'hC8;
    check_outs("R5 write at new base");
    bus_read(16'h1246, 1'b1, 8'h30, "R5 pins at new base");
    bus_read(16'h1240, 1'b1, 8'h05, "R5 index at new base");

    // R2 disable again
    cfg_set(2'd0, 8'h00);
    bus_read(16'h1242, 1'b1 ^ 1'b1, 8'h00, "R2 read after disable");
    bus_write(16'h1242, 8'hDD);
    check_outs("R2 write after disable");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule